// File: doc/BRIEF.md
# AXI Security-Aware Address Decoder

This block sits on an AXI path between a master and a set of slave regions. The protection security bit is treated as an extra, most-significant address bit. Secure and non-secure requests therefore index two separate address spaces. A request that is allowed into a region is passed downstream with a region index. A request that is not allowed is absorbed and answered inside the block, and the slave side never sees it.

Parameters define the region map. Each region has a base, a size and a secure flag. A secure request may enter any region. A non-secure request may enter only regions whose secure flag is clear. When a non-secure request falls only on secure regions, the block drains the transaction and answers it with a configurable response code. When an address falls in no region at all, the answer is always a decode error. Each channel direction holds at most one transaction at a time.

Top module: `axi_sec_decoder`

## Requirements
- R1: The security of a write is taken from bit 1 of `s_awprot`: 0 is secure and 1 is non-secure. An allowed write is forwarded on `m_aw*` with `m_awsel` set to the region index. Its W beats pass through, and the slave's B response is returned with the slave's ID and code.
- R2: The security of a read is taken from bit 1 of `s_arprot`, with the same encoding. An allowed read is forwarded on `m_ar*` with `m_arsel` set to the region index. The slave's R beats (data, ID, response, last) are returned unchanged.
- R3: A non-secure request is never forwarded into a region whose secure flag is set.
- R4: A secure request is forwarded into non-secure regions as well as secure ones.
- R5: A rejected write is accepted on AW. All of its W beats, up to and including the one with WLAST, are accepted and dropped, and none reaches `m_w*`. Exactly one B response then follows, with `s_bid` equal to the request's AWID.
- R6: A rejected read returns ARLEN+1 beats with zero data and the reject code. `s_rlast` is high on the final beat only, and `s_rid` equals the request's ARID. Nothing is issued on `m_ar*`.
- R7: An address that lies in no region is answered with DECERR (2'b11), whatever its security bit.
- R8: Parameter `SEC_RESP` sets the code for a non-secure hit on a secure region: 2'b00 gives OKAY (a silent failure), 2'b10 gives SLVERR (the default) and 2'b11 gives DECERR.
- R9: A region matches when base <= address < base + size. When several regions are allowed, the lowest index wins.
- R10: Each direction accepts a new address only after the previous response has completed. A B or R response that is stalled by a low ready keeps its valid, ID, code and data unchanged.
- R11: Out of reset, `s_bvalid`, `s_rvalid`, `m_awvalid` and `m_arvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_awid | input | ID_W | Write ID |
| s_awlen | input | 8 | Write beats minus one |
| s_awprot | input | 3 | Write protection; bit 1 = non-secure |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wlast | input | 1 | Last write beat |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| s_arid | input | ID_W | Read ID |
| s_arlen | input | 8 | Read beats minus one |
| s_arprot | input | 3 | Read protection; bit 1 = non-secure |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rid | output | ID_W | Read ID |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Last read beat |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_awaddr | output | ADDR_W | Forwarded write address |
| m_awid | output | ID_W | Forwarded write ID |
| m_awlen | output | 8 | Forwarded write length |
| m_awprot | output | 3 | Forwarded write protection |
| m_awsel | output | SEL_W | Target region index for the write |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_wdata | output | DATA_W | Forwarded write data |
| m_wlast | output | 1 | Forwarded last beat |
| m_bvalid | input | 1 | Slave write response valid |
| m_bready | output | 1 | Slave write response ready |
| m_bid | input | ID_W | Slave write response ID |
| m_bresp | input | 2 | Slave write response code |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_araddr | output | ADDR_W | Forwarded read address |
| m_arid | output | ID_W | Forwarded read ID |
| m_arlen | output | 8 | Forwarded read length |
| m_arprot | output | 3 | Forwarded read protection |
| m_arsel | output | SEL_W | Target region index for the read |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Slave read data ready |
| m_rdata | input | DATA_W | Slave read data |
| m_rid | input | ID_W | Slave read ID |
| m_rresp | input | 2 | Slave read response code |
| m_rlast | input | 1 | Slave last read beat |

## Verification
The assertions check several properties on every cycle:
- a forwarded address never pairs a non-secure request with a secure region;
- a stalled B or R response stays unchanged;
- an accepted address drops ready until its response has finished;
- a drained last write beat is followed at once by a B response;
- a final read beat ends the read.

Some behaviour only the bench scenarios can show:
- which region index is chosen at the edges of each range;
- that the beat counts and IDs of rejected bursts are exact;
- that nothing leaks to the slave side;
- that the response code changes with `SEC_RESP`, shown by a second instance in silent mode run side by side.

// File: rtl/axi_sd_pkg.sv
package axi_sd_pkg;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FWD_DATA,
        W_FWD_RESP,
        W_ERR_DATA,
        W_ERR_RESP
    } wr_state_e;

    typedef enum logic [1:0] {
        R_IDLE,
        R_FWD,
        R_ERR
    } rd_state_e;

endpackage

// File: rtl/axi_sd_region_dec.sv
module axi_sd_region_dec
    import axi_sd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned SEL_W       = 2,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE = '0,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_SIZE = '0,
    parameter logic [NUM_REGIONS-1:0]             REGION_SECURE = '0,
    parameter logic [1:0] SEC_RESP = RESP_SLVERR
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ns,
    output logic              fwd,
    output logic [SEL_W-1:0]  sel,
    output logic [1:0]        err_resp
);

    logic [NUM_REGIONS-1:0] in_rng;
    logic [NUM_REGIONS-1:0] allowed;

    // The security bit acts as the top key bit: a non-secure key cannot
    // land on a secure region.
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        assign in_rng[i]  = (addr >= REGION_BASE[i]) &&
                            ((addr - REGION_BASE[i]) < REGION_SIZE[i]);
        assign allowed[i] = in_rng[i] && (!REGION_SECURE[i] || !ns);
    end

    always_comb begin
        sel = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (allowed[i]) sel = SEL_W'(i);
        end
        fwd      = |allowed;
        err_resp = (|in_rng) ? SEC_RESP : RESP_DECERR;
    end

endmodule

// File: rtl/axi_sd_wr_path.sv
module axi_sd_wr_path
    import axi_sd_pkg::*;
#(
    parameter int unsigned ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_fwd,
    input  logic [1:0]      dec_resp,
    input  logic            s_awvalid,
    output logic            s_awready,
    input  logic [ID_W-1:0] s_awid,
    input  logic            s_wvalid,
    output logic            s_wready,
    input  logic            s_wlast,
    output logic            s_bvalid,
    input  logic            s_bready,
    output logic [ID_W-1:0] s_bid,
    output logic [1:0]      s_bresp,
    output logic            m_awvalid,
    input  logic            m_awready,
    output logic            m_wvalid,
    input  logic            m_wready,
    input  logic            m_bvalid,
    output logic            m_bready,
    input  logic [ID_W-1:0] m_bid,
    input  logic [1:0]      m_bresp
);

    typedef struct packed {
        wr_state_e       st;
        logic [ID_W-1:0] id;
        logic [1:0]      code;
    } wr_reg_t;

    wr_reg_t wr_q, wr_d;

    always_comb begin
        wr_d      = wr_q;
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_bvalid  = 1'b0;
        s_bid     = wr_q.id;
        s_bresp   = wr_q.code;
        m_awvalid = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        unique case (wr_q.st)
            W_IDLE: begin
                if (s_awvalid) begin
                    if (dec_fwd) begin
                        m_awvalid = 1'b1;
                        s_awready = m_awready;
                        if (m_awready) wr_d.st = W_FWD_DATA;
                    end else begin
                        s_awready = 1'b1;
                        wr_d.st   = W_ERR_DATA;
                        wr_d.id   = s_awid;
                        wr_d.code = dec_resp;
                    end
                end
            end
            W_FWD_DATA: begin
                m_wvalid = s_wvalid;
                s_wready = m_wready;
                if (s_wvalid && m_wready && s_wlast) wr_d.st = W_FWD_RESP;
            end
            W_FWD_RESP: begin
                s_bvalid = m_bvalid;
                m_bready = s_bready;
                s_bid    = m_bid;
                s_bresp  = m_bresp;
                if (m_bvalid && s_bready) wr_d.st = W_IDLE;
            end
            W_ERR_DATA: begin
                s_wready = 1'b1;
                if (s_wvalid && s_wlast) wr_d.st = W_ERR_RESP;
            end
            W_ERR_RESP: begin
                s_bvalid = 1'b1;
                if (s_bready) wr_d.st = W_IDLE;
            end
            default: wr_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= '{st: W_IDLE, id: '0, code: '0};
        else        wr_q <= wr_d;
    end

    // R10
    bhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bid) && $stable(s_bresp));

    // R10
    aw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_awvalid && s_awready |=> !s_awready);

    // R5
    drain_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_wvalid && s_wready && s_wlast && !m_wvalid |=> s_bvalid);

endmodule

// File: rtl/axi_sd_rd_path.sv
module axi_sd_rd_path
    import axi_sd_pkg::*;
#(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_fwd,
    input  logic [1:0]        dec_resp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ID_W-1:0]   s_arid,
    input  logic [7:0]        s_arlen,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [ID_W-1:0]   s_rid,
    output logic [1:0]        s_rresp,
    output logic              s_rlast,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [ID_W-1:0]   m_rid,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast
);

    typedef struct packed {
        rd_state_e       st;
        logic [ID_W-1:0] id;
        logic [1:0]      code;
        logic [7:0]      left;
    } rd_reg_t;

    rd_reg_t rd_q, rd_d;

    always_comb begin
        rd_d      = rd_q;
        s_arready = 1'b0;
        s_rvalid  = 1'b0;
        s_rdata   = '0;
        s_rid     = rd_q.id;
        s_rresp   = rd_q.code;
        s_rlast   = 1'b0;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        unique case (rd_q.st)
            R_IDLE: begin
                if (s_arvalid) begin
                    if (dec_fwd) begin
                        m_arvalid = 1'b1;
                        s_arready = m_arready;
                        if (m_arready) rd_d.st = R_FWD;
                    end else begin
                        s_arready = 1'b1;
                        rd_d.st   = R_ERR;
                        rd_d.id   = s_arid;
                        rd_d.code = dec_resp;
                        rd_d.left = s_arlen;
                    end
                end
            end
            R_FWD: begin
                s_rvalid = m_rvalid;
                m_rready = s_rready;
                s_rdata  = m_rdata;
                s_rid    = m_rid;
                s_rresp  = m_rresp;
                s_rlast  = m_rlast;
                if (m_rvalid && s_rready && m_rlast) rd_d.st = R_IDLE;
            end
            R_ERR: begin
                s_rvalid = 1'b1;
                s_rlast  = (rd_q.left == '0);
                if (s_rready) begin
                    if (rd_q.left == '0) rd_d.st = R_IDLE;
                    else                 rd_d.left = rd_q.left - 8'd1;
                end
            end
            default: rd_d.st = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '{st: R_IDLE, id: '0, code: '0, left: '0};
        else        rd_q <= rd_d;
    end

    // R10
    rhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rid) && $stable(s_rdata)
                                  && $stable(s_rresp) && $stable(s_rlast));

    // R6
    rlast_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && s_rready && s_rlast |=> !s_rvalid);

    // R10
    ar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready |=> !s_arready);

endmodule

// File: rtl/axi_sec_decoder.sv
module axi_sec_decoder
    import axi_sd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ID_W        = 4,
    parameter int unsigned NUM_REGIONS = 4,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE =
        {32'h0002_0000, 32'h0001_0000, 32'h0000_1000, 32'h0000_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_SIZE =
        {32'h0000_0100, 32'h0001_0000, 32'h0000_1000, 32'h0000_1000},
    parameter logic [NUM_REGIONS-1:0] REGION_SECURE = 4'b1010,
    parameter logic [1:0] SEC_RESP = RESP_SLVERR,
    localparam int unsigned SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [ID_W-1:0]   s_awid,
    input  logic [7:0]        s_awlen,
    input  logic [2:0]        s_awprot,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              s_wlast,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [ID_W-1:0]   s_bid,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [ID_W-1:0]   s_arid,
    input  logic [7:0]        s_arlen,
    input  logic [2:0]        s_arprot,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [ID_W-1:0]   s_rid,
    output logic [1:0]        s_rresp,
    output logic              s_rlast,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [ID_W-1:0]   m_awid,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awprot,
    output logic [SEL_W-1:0]  m_awsel,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_wlast,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [ID_W-1:0]   m_bid,
    input  logic [1:0]        m_bresp,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [ID_W-1:0]   m_arid,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arprot,
    output logic [SEL_W-1:0]  m_arsel,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [ID_W-1:0]   m_rid,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast
);

    logic       aw_fwd, ar_fwd;
    logic [1:0] aw_err, ar_err;

    axi_sd_region_dec #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W),
        .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE),
        .REGION_SECURE(REGION_SECURE), .SEC_RESP(SEC_RESP)
    ) u_aw_dec (
        .addr(s_awaddr), .ns(s_awprot[1]),
        .fwd(aw_fwd), .sel(m_awsel), .err_resp(aw_err)
    );

    axi_sd_region_dec #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W),
        .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE),
        .REGION_SECURE(REGION_SECURE), .SEC_RESP(SEC_RESP)
    ) u_ar_dec (
        .addr(s_araddr), .ns(s_arprot[1]),
        .fwd(ar_fwd), .sel(m_arsel), .err_resp(ar_err)
    );

    axi_sd_wr_path #(.ID_W(ID_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .dec_fwd(aw_fwd), .dec_resp(aw_err),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wlast(s_wlast),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp)
    );

    axi_sd_rd_path #(.ID_W(ID_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .dec_fwd(ar_fwd), .dec_resp(ar_err),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arid(s_arid), .s_arlen(s_arlen),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
        .s_rid(s_rid), .s_rresp(s_rresp), .s_rlast(s_rlast),
        .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
        .m_rid(m_rid), .m_rresp(m_rresp), .m_rlast(m_rlast)
    );

    assign m_awaddr = s_awaddr;
    assign m_awid   = s_awid;
    assign m_awlen  = s_awlen;
    assign m_awprot = s_awprot;
    assign m_wdata  = s_wdata;
    assign m_wlast  = s_wlast;
    assign m_araddr = s_araddr;
    assign m_arid   = s_arid;
    assign m_arlen  = s_arlen;
    assign m_arprot = s_arprot;

    // R3
    awsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> !(m_awprot[1] && REGION_SECURE[m_awsel]));

    // R3
    arsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> !(m_arprot[1] && REGION_SECURE[m_arsel]));

endmodule

// File: tb/axi_sec_decoder_bench.sv
`timescale 1ns/1ps
module axi_sec_decoder_bench;

    localparam logic [1:0] OKAY = 2'b00, SLVERR = 2'b10, DECERR = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    initial forever #2.5 clk = ~clk;

    logic        s_awvalid = 0, s_wvalid = 0, s_wlast = 0, s_arvalid = 0;
    logic [31:0] s_awaddr = 0, s_araddr = 0, s_wdata = 0;
    logic [3:0]  s_awid = 0, s_arid = 0;
    logic [7:0]  s_awlen = 0, s_arlen = 0;
    logic [2:0]  s_awprot = 0, s_arprot = 0;
    logic        s_bready = 1, s_rready = 1;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, s_rlast;
    logic [3:0]  s_bid, s_rid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;

    logic        m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
    logic [31:0] m_awaddr, m_araddr, m_wdata;
    logic [3:0]  m_awid, m_arid;
    logic [7:0]  m_awlen, m_arlen;
    logic [2:0]  m_awprot, m_arprot;
    logic [1:0]  m_awsel, m_arsel;
    logic        m_bvalid = 0, m_rvalid = 0, m_rlast = 0;
    logic [3:0]  m_bid = 0, m_rid = 0;
    logic [1:0]  m_bresp = 0, m_rresp = 0;
    logic [31:0] m_rdata = 0;

    // second instance (silent mode) outputs
    logic        x_awready, x_wready, x_bvalid, x_arready, x_rvalid, x_rlast;
    logic [3:0]  x_bid, x_rid, x_awid, x_arid;
    logic [1:0]  x_bresp, x_rresp, x_awsel, x_arsel;
    logic [31:0] x_rdata, x_awaddr, x_araddr, x_wdata;
    logic        x_awvalid, x_wvalid, x_wlast, x_bready, x_arvalid, x_rready;
    logic [7:0]  x_awlen, x_arlen;
    logic [2:0]  x_awprot, x_arprot;

    axi_sec_decoder u_axi_sec_decoder (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awid(s_awid),
        .s_awlen(s_awlen), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arid(s_arid),
        .s_arlen(s_arlen), .s_arprot(s_arprot),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rid(s_rid),
        .s_rresp(s_rresp), .s_rlast(s_rlast),
        .m_awvalid(m_awvalid), .m_awready(1'b1), .m_awaddr(m_awaddr), .m_awid(m_awid),
        .m_awlen(m_awlen), .m_awprot(m_awprot), .m_awsel(m_awsel),
        .m_wvalid(m_wvalid), .m_wready(1'b1), .m_wdata(m_wdata), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bid(m_bid), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(1'b1), .m_araddr(m_araddr), .m_arid(m_arid),
        .m_arlen(m_arlen), .m_arprot(m_arprot), .m_arsel(m_arsel),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rid(m_rid),
        .m_rresp(m_rresp), .m_rlast(m_rlast)
    );

    axi_sec_decoder #(.SEC_RESP(2'b00)) u_axi_sec_decoder_silent (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(x_awready), .s_awaddr(s_awaddr), .s_awid(s_awid),
        .s_awlen(s_awlen), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(x_wready), .s_wdata(s_wdata), .s_wlast(s_wlast),
        .s_bvalid(x_bvalid), .s_bready(s_bready), .s_bid(x_bid), .s_bresp(x_bresp),
        .s_arvalid(s_arvalid), .s_arready(x_arready), .s_araddr(s_araddr), .s_arid(s_arid),
        .s_arlen(s_arlen), .s_arprot(s_arprot),
        .s_rvalid(x_rvalid), .s_rready(s_rready), .s_rdata(x_rdata), .s_rid(x_rid),
        .s_rresp(x_rresp), .s_rlast(x_rlast),
        .m_awvalid(x_awvalid), .m_awready(1'b1), .m_awaddr(x_awaddr), .m_awid(x_awid),
        .m_awlen(x_awlen), .m_awprot(x_awprot), .m_awsel(x_awsel),
        .m_wvalid(x_wvalid), .m_wready(1'b1), .m_wdata(x_wdata), .m_wlast(x_wlast),
        .m_bvalid(m_bvalid), .m_bready(x_bready), .m_bid(m_bid), .m_bresp(m_bresp),
        .m_arvalid(x_arvalid), .m_arready(1'b1), .m_araddr(x_araddr), .m_arid(x_arid),
        .m_arlen(x_arlen), .m_arprot(x_arprot), .m_arsel(x_arsel),
        .m_rvalid(m_rvalid), .m_rready(x_rready), .m_rdata(m_rdata), .m_rid(m_rid),
        .m_rresp(m_rresp), .m_rlast(m_rlast)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [3:0] id;
        logic [1:0] resp;
        logic [7:0] len;
        bit         fwd;
        logic [1:0] sel;
        string      req;
    } exp_t;

    exp_t bq[$];
    exp_t rq[$];

    // downstream slave model
    int aw_cnt = 0, w_cnt = 0, ar_cnt = 0;
    logic [1:0] aw_sel_seen = 0, ar_sel_seen = 0;

    initial begin : slave_wr
        logic [3:0] cap_id = 0;
        forever begin
            bit aw_hs, w_hs, wl, b_hs;
            @(negedge clk);
            aw_hs = m_awvalid;
            w_hs  = m_wvalid;
            wl    = m_wlast;
            b_hs  = m_bvalid && m_bready;
            if (aw_hs) begin aw_cnt++; aw_sel_seen = m_awsel; cap_id = m_awid; end
            if (w_hs) w_cnt++;
            @(posedge clk); #1;
            if (b_hs) m_bvalid = 0;
            if (w_hs && wl) begin m_bvalid = 1; m_bid = cap_id; m_bresp = OKAY; end
        end
    end

    initial begin : slave_rd
        logic [3:0] cid = 0;
        logic [7:0] clen = 0;
        logic [1:0] csel = 0;
        int beat = 0;
        forever begin
            bit ar_hs, r_hs, rl;
            @(negedge clk);
            ar_hs = m_arvalid;
            r_hs  = m_rvalid && m_rready;
            rl    = m_rlast;
            if (ar_hs) begin ar_cnt++; ar_sel_seen = m_arsel; end
            @(posedge clk); #1;
            if (r_hs) begin
                if (rl) m_rvalid = 0;
                else    beat++;
            end
            if (ar_hs) begin
                cid = m_arid; clen = m_arlen; csel = m_arsel; beat = 0; m_rvalid = 1;
            end
            m_rid   = cid;
            m_rresp = OKAY;
            m_rdata = {8'(csel), 8'(cid), 16'(beat)};
            m_rlast = (beat == int'(clen));
        end
    end

    // ready pattern for stall tests
    bit bp = 0;
    initial begin : ready_gen
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            s_bready = bp ? cyc[1] : 1'b1;
            s_rready = bp ? cyc[1] : 1'b1;
        end
    end

    // B monitor
    initial begin : mon_b
        forever begin
            @(negedge clk);
            if (s_bvalid && s_bready) begin
                if (bq.size() == 0) chk(0, "R5", "unexpected B", 32'(s_bid), 0);
                else begin
                    exp_t e;
                    e = bq.pop_front();
                    chk(s_bid == e.id, e.req, "bid", 32'(s_bid), 32'(e.id));
                    chk(s_bresp == e.resp, e.req, "bresp", 32'(s_bresp), 32'(e.resp));
                    // R8: the silent instance gives OKAY where the default gives SLVERR
                    chk(x_bvalid && x_bid == e.id &&
                        x_bresp == ((e.resp == SLVERR) ? OKAY : e.resp),
                        "R8", "silent bresp", 32'(x_bresp), 32'((e.resp == SLVERR) ? OKAY : e.resp));
                end
            end
        end
    end

    // R monitor
    initial begin : mon_r
        int beat = 0;
        bit stall = 0;
        logic [31:0] p_data = 0;
        logic [3:0]  p_id = 0;
        forever begin
            @(negedge clk);
            if (stall)  // R10: stalled beat must hold
                chk(s_rvalid && s_rdata == p_data && s_rid == p_id, "R10", "r hold",
                    s_rdata, p_data);
            stall  = s_rvalid && !s_rready;
            p_data = s_rdata;
            p_id   = s_rid;
            if (s_rvalid && s_rready) begin
                if (rq.size() == 0) chk(0, "R6", "unexpected R", 32'(s_rid), 0);
                else begin
                    exp_t e;
                    logic [31:0] ed;
                    logic [1:0]  er;
                    e  = rq[0];
                    ed = e.fwd ? {8'(e.sel), 8'(e.id), 16'(beat)} : 32'h0;
                    er = e.fwd ? OKAY : e.resp;
                    chk(s_rid == e.id, e.req, "rid", 32'(s_rid), 32'(e.id));
                    chk(s_rresp == er, e.req, "rresp", 32'(s_rresp), 32'(er));
                    chk(s_rdata == ed, e.req, "rdata", s_rdata, ed);
                    chk(s_rlast == (beat == int'(e.len)), e.req, "rlast",
                        32'(s_rlast), 32'(beat == int'(e.len)));
                    chk(x_rvalid && x_rresp == ((er == SLVERR) ? OKAY : er) &&
                        x_rdata == ed, "R8", "silent rresp", 32'(x_rresp),
                        32'((er == SLVERR) ? OKAY : er));
                    if (s_rlast) begin beat = 0; void'(rq.pop_front()); end
                    else beat++;
                end
            end
        end
    end

    task automatic wr(input logic [31:0] addr, input bit ns, input logic [3:0] id,
                      input logic [7:0] len, input logic [1:0] resp, input bit fwd,
                      input logic [1:0] sel, input string req);
        int a0, w0;
        exp_t e;
        e.id = id; e.resp = resp; e.len = len; e.fwd = fwd; e.sel = sel; e.req = req;
        bq.push_back(e);
        a0 = aw_cnt; w0 = w_cnt;
        @(posedge clk); #1;
        s_awvalid = 1; s_awaddr = addr; s_awid = id; s_awlen = len;
        s_awprot = {1'b0, ns, 1'b0};
        do @(negedge clk); while (!s_awready);
        @(posedge clk); #1;
        s_awvalid = 0;
        for (int b = 0; b <= int'(len); b++) begin
            s_wvalid = 1; s_wdata = 32'hA500_0000 + 32'(b); s_wlast = (b == int'(len));
            do @(negedge clk); while (!s_wready);
            @(posedge clk); #1;
        end
        s_wvalid = 0; s_wlast = 0;
        while (bq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(aw_cnt - a0 == (fwd ? 1 : 0), req, "aw forwarded", 32'(aw_cnt - a0), 32'(fwd));
        chk(w_cnt - w0 == (fwd ? int'(len) + 1 : 0), req, "w beats forwarded",
            32'(w_cnt - w0), fwd ? 32'(len) + 1 : 0);
        if (fwd) chk(aw_sel_seen == sel, req, "awsel", 32'(aw_sel_seen), 32'(sel));
    endtask

    task automatic rd(input logic [31:0] addr, input bit ns, input logic [3:0] id,
                      input logic [7:0] len, input logic [1:0] resp, input bit fwd,
                      input logic [1:0] sel, input string req);
        int a0;
        exp_t e;
        e.id = id; e.resp = resp; e.len = len; e.fwd = fwd; e.sel = sel; e.req = req;
        rq.push_back(e);
        a0 = ar_cnt;
        @(posedge clk); #1;
        s_arvalid = 1; s_araddr = addr; s_arid = id; s_arlen = len;
        s_arprot = {1'b0, ns, 1'b0};
        do @(negedge clk); while (!s_arready);
        @(posedge clk); #1;
        s_arvalid = 0;
        while (rq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ar_cnt - a0 == (fwd ? 1 : 0), req, "ar forwarded", 32'(ar_cnt - a0), 32'(fwd));
        if (fwd) chk(ar_sel_seen == sel, req, "arsel", 32'(ar_sel_seen), 32'(sel));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual hung expected complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11
        chk(!s_bvalid && !s_rvalid && !m_awvalid && !m_arvalid, "R11", "reset outputs",
            {s_bvalid, s_rvalid, m_awvalid, m_arvalid}, 0);

        // writes
        wr(32'h0000_1010, 0, 4'h1, 8'd0, OKAY,   1, 2'd1, "R1");
        wr(32'h0000_1010, 1, 4'h2, 8'd3, SLVERR, 0, 2'd0, "R5");
        wr(32'h0000_0008, 1, 4'h3, 8'd1, OKAY,   1, 2'd0, "R1");
        wr(32'h0001_8000, 0, 4'h4, 8'd2, OKAY,   1, 2'd2, "R4");
        wr(32'h0002_0000, 1, 4'h5, 8'd0, SLVERR, 0, 2'd0, "R3");
        wr(32'h0005_0000, 1, 4'h6, 8'd1, DECERR, 0, 2'd0, "R7");
        wr(32'h0000_3000, 0, 4'h7, 8'd0, DECERR, 0, 2'd0, "R7");

        // reads
        rd(32'h0002_0010, 0, 4'h8, 8'd2, OKAY,   1, 2'd3, "R2");
        rd(32'h0002_0010, 1, 4'h9, 8'd3, SLVERR, 0, 2'd0, "R6");
        rd(32'h0001_0000, 1, 4'hA, 8'd1, OKAY,   1, 2'd2, "R4");
        rd(32'h0005_0000, 0, 4'hB, 8'd0, DECERR, 0, 2'd0, "R7");

        // range edges
        rd(32'h0000_0FFF, 1, 4'hC, 8'd0, OKAY,   1, 2'd0, "R9");
        rd(32'h0000_1000, 1, 4'hD, 8'd0, SLVERR, 0, 2'd0, "R9");
        rd(32'h0000_1FFF, 0, 4'hE, 8'd0, OKAY,   1, 2'd1, "R9");
        rd(32'h0000_2000, 0, 4'hF, 8'd0, DECERR, 0, 2'd0, "R9");

        // stalled responses
        bp = 1;
        rd(32'h0000_1100, 1, 4'h1, 8'd4, SLVERR, 0, 2'd0, "R10");
        rd(32'h0000_0100, 0, 4'h2, 8'd3, OKAY,   1, 2'd0, "R10");
        wr(32'h0000_1200, 1, 4'h3, 8'd2, SLVERR, 0, 2'd0, "R10");
        bp = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule